// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block captures a parallel word into a chain of stages and then streams it out one bit at a time from the last stage. Each shift moves every stage one place toward the last stage, and the first stage takes a new bit from a serial input. The last stage drives a true serial output and a complemented serial output. Because of the serial input, several copies can be chained: the true output of one feeds the serial input of the next, and the whole chain then converts a longer word.

The block runs on one system clock. It samples an external shift clock and an active-high inhibit, and treats their OR as the effective clock. A shift happens on each rising edge of that effective clock. An active-low load input takes priority over shifting. While load is low, the parallel word is written into the stages on every system clock, and the serial outputs show the last parallel bit in the same cycle.

Top module: `piso_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage and the edge history. After reset, with load high, `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is 0, `ser_out` equals `par_in[WIDTH-1]` in the same cycle. The stages take `par_in` (bit i into stage i) on every system clock edge.
- R3: With `load_n` high, a 0-to-1 change of the effective clock (`sclk | inhibit`) shifts stage i into stage i+1 and `ser_in` into stage 0. The new last stage shows on `ser_out` by the second system clock edge after the change is presented.
- R4: With `load_n` high and `inhibit` high, the stages hold their contents however `sclk` moves.
- R5: The effective clock is the OR of `sclk` and `inhibit`. A rise of `inhibit` while `sclk` is low causes a shift. A fall of `inhibit` while `sclk` is high causes no shift.
- R6: Releasing `load_n` while the effective clock is already high causes no shift. No shift happens until the effective clock next goes from 0 to 1.
- R7: `ser_out_n` is always the complement of `ser_out`.
- R8: Two instances can be chained by tying the first one's `ser_out` to the second one's `ser_in`. After both are loaded, the second one's `ser_out` gives 2*WIDTH bits over successive shifts: its own word from the most significant bit down, then the first instance's word from the most significant bit down.
- R9: Load has priority over shifting. Edges of `sclk` while `load_n` is 0 leave the stages equal to `par_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load |
| sclk | input | 1 | External shift clock, sampled on clk |
| inhibit | input | 1 | Active-high clock inhibit, ORed into the shift clock |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data, bit i into stage i |
| ser_out | output | 1 | Last stage, true |
| ser_out_n | output | 1 | Last stage, complemented |

## Verification
The hardest cases to reach are the ones where the effective clock changes because of `inhibit` rather than `sclk`, or where the load is released while that clock is already high. These must produce a shift, or no shift, without any `sclk` edge at all. The bench reaches them with directed sequences. It raises `inhibit` with `sclk` held low. It drops `inhibit` with `sclk` held high. It releases the load with `sclk` held high. Each time it reads the last stage before and after, using a parallel word whose top two bits differ, so a single stray shift shows at the output.

// File: rtl/piso_shifter.sv
module piso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             sclk,
  input  logic             inhibit,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int TOP = WIDTH - 1;

  logic [TOP:0] stage;
  logic         eff_q;
  logic         eff_prev;
  logic         shift_fire;

  assign shift_fire = load_n & eff_q & ~eff_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      eff_q    <= 1'b0;
      eff_prev <= 1'b0;
    end else begin
      eff_q <= sclk | inhibit;
      if (!load_n) begin
        stage    <= par_in;
        eff_prev <= sclk | inhibit;
      end else begin
        eff_prev <= eff_q;
        if (shift_fire)
          stage <= {stage[TOP-1:0], ser_in};
      end
    end
  end

  assign ser_out   = load_n ? stage[TOP] : par_in[TOP];
  assign ser_out_n = ~ser_out;
endmodule

// File: rtl/piso_shifter_checks.sv
module piso_shifter_checks #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage,
  input logic             eff_q,
  input logic             eff_prev,
  input logic             ser_out,
  input logic             ser_out_n
);
  assert_compl_R7: assert property (@(posedge clk) disable iff (rst)
    ser_out_n == !ser_out);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && load_n) |-> (ser_out == 1'b0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> stage == $past(par_in));

  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (load_n && eff_q && !eff_prev) |=>
      stage == {$past(stage[WIDTH-2:0]), $past(ser_in)});

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (load_n && !(eff_q && !eff_prev)) |=> $stable(stage));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> !(eff_q && !eff_prev));
endmodule

bind piso_shifter piso_shifter_checks #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rst(rst), .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
  .stage(stage), .eff_q(eff_q), .eff_prev(eff_prev),
  .ser_out(ser_out), .ser_out_n(ser_out_n)
);

// File: tb/piso_shifter_test.sv
module piso_shifter_test;
  logic clk = 1'b0;
  logic rst, load_n, sclk, inhibit, sin;
  logic [7:0] par_a, par_b;
  logic out_a, out_a_n, out_b, out_b_n;
  int checks = 0, fails = 0;
  logic [7:0] mdl;

  always #2.5 clk = ~clk;

  piso_shifter #(.WIDTH(8)) uut (
    .clk(clk), .rst(rst), .load_n(load_n), .sclk(sclk), .inhibit(inhibit),
    .ser_in(sin), .par_in(par_a), .ser_out(out_a), .ser_out_n(out_a_n));

  piso_shifter #(.WIDTH(8)) nxt (
    .clk(clk), .rst(rst), .load_n(load_n), .sclk(sclk), .inhibit(inhibit),
    .ser_in(out_a), .par_in(par_b), .ser_out(out_b), .ser_out_n(out_b_n));

  localparam logic [15:0] VEC [5] = '{16'hA53C, 16'hFF00, 16'h00FF, 16'h817E, 16'h5AC3};

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_a(input logic exp, input string req);
    chk(out_a, exp, req);
    chk(out_a_n, ~exp, "R7");
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; cyc(2);
    sclk = 1'b0; cyc(2);
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] b);
    par_a = a; par_b = b; load_n = 1'b0; cyc(1);
    chk_a(a[7], "R2");
    load_n = 1'b1; cyc(2);
    mdl = a;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; load_n = 1'b1; sclk = 1'b0; inhibit = 1'b0; sin = 1'b0;
    par_a = 8'hFF; par_b = 8'hFF;
    cyc(3);
    rst = 1'b0; cyc(1);
    chk_a(1'b0, "R1");
    chk(out_b, 1'b0, "R1");

    foreach (VEC[v]) begin
      load(VEC[v][15:8], 8'h00);
      chk_a(mdl[7], "R2");
      for (int k = 0; k < 8; k++) begin
        sin = VEC[v][8 - 8 + k];
        pulse();
        mdl = {mdl[6:0], sin};
        chk_a(mdl[7], "R3");
      end
    end

    // R4: hold under inhibit, then bring contents out
    load(8'hA5, 8'h00);
    sin = 1'b0;
    inhibit = 1'b1; cyc(2);
    mdl = {mdl[6:0], 1'b0};
    for (int k = 0; k < 3; k++) pulse();
    chk_a(mdl[7], "R4");
    inhibit = 1'b0; cyc(2);
    chk_a(mdl[7], "R4");
    for (int k = 0; k < 7; k++) begin
      pulse();
      mdl = {mdl[6:0], 1'b0};
      chk_a(mdl[7], "R4");
    end

    // R5: inhibit rise with sclk low shifts; inhibit fall with sclk high does not
    load(8'hA5, 8'h00);
    inhibit = 1'b1; cyc(3);
    chk_a(1'b0, "R5");
    sclk = 1'b1; cyc(2);
    inhibit = 1'b0; cyc(3);
    chk_a(1'b0, "R5");
    sclk = 1'b0; cyc(2);
    pulse();
    chk_a(1'b1, "R5");

    // R6: load released with sclk high
    sclk = 1'b1; cyc(2);
    par_a = 8'hB0; load_n = 1'b0; cyc(2);
    load_n = 1'b1; cyc(3);
    chk_a(1'b1, "R6");
    sclk = 1'b0; cyc(3);
    chk_a(1'b1, "R6");
    pulse();
    chk_a(1'b0, "R6");

    // R9: sclk edges during load
    par_a = 8'h60; load_n = 1'b0;
    pulse(); pulse();
    chk_a(1'b0, "R9");
    load_n = 1'b1; cyc(2);
    chk_a(1'b0, "R9");
    pulse();
    chk_a(1'b1, "R9");
    pulse();
    chk_a(1'b1, "R9");
    pulse();
    chk_a(1'b0, "R9");

    // R8: two-instance cascade, 16 bits out of the second
    sin = 1'b0;
    load(8'hC3, 8'h96);
    for (int k = 0; k < 16; k++) begin
      logic e;
      e = (k < 8) ? par_b[7 - k] : par_a[15 - k];
      chk(out_b, e, "R8");
      chk(out_b_n, ~e, "R7");
      pulse();
    end

    // R1: reset clears loaded content
    load(8'hFF, 8'hFF);
    rst = 1'b1; cyc(2);
    rst = 1'b0; cyc(1);
    chk_a(1'b0, "R1");
    chk(out_b, 1'b0, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule